// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Out-of-Range Policy

This unit turns an IEEE 754 binary64 or binary32 operand into a 32-bit or 64-bit integer. The integer can be signed or unsigned. The operand is first rounded to an integral value under a two-bit rounding mode, or always toward zero when a force input is high. Three policies cover NaN, infinity and values that do not fit. Policy P saturates and maps NaN to the smallest result. Policy S saturates and maps NaN to zero. Policy E keeps the low w bits of the rounded two's-complement value and gives zero for NaN and for both infinities.

The unit also produces an exactness flag. The flag is raised whenever the integer result is not exactly the operand value. Alongside it comes a condition nibble that compares the result with zero and carries a sticky summary of the exactness flag. A conversion is applied while `cvt_en` is high. Its result appears on the registered outputs one clock later.

Top module: `fp2int_cvt`

## Requirements
- R1: The rounding mode is encoded as 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. When `force_rtz` is 1, toward zero is used whatever `rmode` holds.
- R2: When `kind` is 00 (P), a NaN gives -2^(w-1) for a signed result and 0 for an unsigned result.
- R3: When `kind` is 01 (S), a NaN gives 0 for both signed and unsigned results.
- R4: Under P and S, +infinity, or a rounded value above the largest result, gives 2^(w-1)-1 when signed and 2^w-1 when unsigned.
- R5: Under P and S, -infinity, or a rounded value below the smallest result, gives -2^(w-1) when signed and 0 when unsigned. A value exactly equal to the minimum is returned unchanged.
- R6: When `kind[1]` is 1 (E), NaN, both infinities and values so large that no bit remains below bit w gives 0. Any other value gives the low w bits of the rounded value in two's complement, for either signedness.
- R7: `ovf` is 1 exactly when the result differs from the operand's value. This covers a discarded fraction, saturation, wrapping and NaN. An exact conversion, including -0.0, gives `ovf` 0.
- R8: `cond[3:1]` holds {less, greater, equal} against zero, with exactly one bit set. The comparison reads `res` as signed when `dst_signed` is 1 and as unsigned otherwise.
- R9: `cond[0]` is a sticky bit. It is set by any conversion with `ovf` 1, including the conversion now on the outputs, and it is cleared only by reset.
- R10: For a 32-bit result (`dst_wide` 0), `res[63:32]` is the sign extension of `res[31]` when signed and zero when unsigned.
- R11: Subnormal operands are converted exactly under the rounding mode. They give 0 or ±1, and `ovf` is set.
- R12: After reset `res` is 0, `ovf` is 0 and `cond` is 4'b0010. Outputs update one clock after a cycle with `cvt_en` 1 and hold while `cvt_en` is 0.
- R13: When `src_dbl` is 0, the operand is the binary32 value in `src_bits[31:0]`, and `src_bits[63:32]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cvt_en | input | 1 | Apply a conversion this cycle |
| src_bits | input | 64 | Operand encoding |
| src_dbl | input | 1 | 1 = binary64, 0 = binary32 in low half |
| dst_wide | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| dst_signed | input | 1 | 1 = signed result |
| kind | input | 2 | 00 P, 01 S, 1x E |
| rmode | input | 2 | Rounding mode (R1 encoding) |
| force_rtz | input | 1 | Force rounding toward zero |
| res | output | 64 | Integer result |
| ovf | output | 1 | Result is not the exact operand value |
| cond | output | 4 | {less, greater, equal, sticky summary} |

## Verification
The only state in the unit is the output register and the sticky summary bit. A wrong internal value therefore shows on the ports at the clock after the conversion that caused it.

A fault in the rounding increment, in the fixed-point alignment or in the range thresholds changes `res` or `ovf` on that same conversion. A sticky bit that clears, or that fails to set, shows in `cond[0]` on the next conversion, at the latest. Vectors are placed on the rounding ties, at the exact signed minimum, one step past each saturation limit, on the full-wrap exponents and on subnormals, so that an off-by-one in any comparison changes an output at once.

// File: rtl/fp2int_cvt.sv
module fp2int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cvt_en,
  input  logic [63:0] src_bits,
  input  logic        src_dbl,
  input  logic        dst_wide,
  input  logic        dst_signed,
  input  logic [1:0]  kind,
  input  logic [1:0]  rmode,
  input  logic        force_rtz,
  output logic [63:0] res,
  output logic        ovf,
  output logic [3:0]  cond
);
  localparam logic [1:0] RM_RNE = 2'd0, RM_RTZ = 2'd1, RM_RUP = 2'd2, RM_RDN = 2'd3;

  logic        sgn, ex_max, ex_zero;
  logic [10:0] ex;
  logic [51:0] fr;

  always_comb begin
    if (src_dbl) begin
      sgn     = src_bits[63];
      ex      = src_bits[62:52];
      fr      = src_bits[51:0];
    end else begin
      sgn     = src_bits[31];
      ex      = {3'b000, src_bits[30:23]};
      fr      = {src_bits[22:0], 29'b0};
    end
    ex_max  = src_dbl ? (&src_bits[62:52]) : (&src_bits[30:23]);
    ex_zero = (ex == 11'd0);
  end

  wire is_nan = ex_max & (|fr);
  wire is_inf = ex_max & ~(|fr);

  // unbiased exponent; subnormals use the minimum normal exponent
  wire signed [12:0] e_unb = $signed({2'b00, ex_zero ? 11'd1 : ex})
                           - (src_dbl ? 13'sd1023 : 13'sd127);
  wire               huge  = e_unb > 13'sd127;
  wire signed [12:0] e3    = e_unb + 13'sd3;
  wire [7:0]         shamt = (e3 < 13'sd1) ? 8'd1 : e3[7:0];

  // 128 integer bits, 55 fraction bits
  wire [52:0]  mant = {~ex_zero, fr};
  wire [182:0] fx   = {130'b0, mant} << shamt;
  wire [127:0] intp = fx[182:55];
  wire         grd  = fx[54];
  wire         stk  = |fx[53:0];
  wire         inexact = grd | stk;

  wire [1:0] rm_eff = force_rtz ? RM_RTZ : rmode;
  logic      inc;
  always_comb begin
    case (rm_eff)
      RM_RNE:  inc = grd & (stk | intp[0]);
      RM_RUP:  inc = ~sgn & inexact;
      RM_RDN:  inc = sgn & inexact;
      default: inc = 1'b0;
    endcase
  end

  wire [128:0] mag   = {1'b0, intp} + 129'(inc);
  wire [128:0] lim_s = 129'd1 << (dst_wide ? 7'd63 : 7'd31);
  wire [128:0] lim_u = 129'd1 << (dst_wide ? 7'd64 : 7'd32);
  wire         big   = huge | is_inf;

  wire too_hi = ~is_nan & ~sgn & (big | (dst_signed ? (mag >= lim_s) : (mag >= lim_u)));
  wire too_lo = ~is_nan &  sgn & (big | (dst_signed ? (mag >  lim_s) : (mag != 129'd0)));

  wire [63:0] min_v = !dst_signed ? 64'd0 :
                      dst_wide    ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
  wire [63:0] max_v = dst_wide ? (dst_signed ? 64'h7FFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF)
                               : (dst_signed ? 64'h0000_0000_7FFF_FFFF : 64'h0000_0000_FFFF_FFFF);

  wire [63:0] twos    = sgn ? (~mag[63:0] + 64'd1) : mag[63:0];
  wire [63:0] low_ext = dst_wide ? twos
                                 : {(dst_signed ? {32{twos[31]}} : 32'b0), twos[31:0]};

  logic [63:0] r_n;
  always_comb begin
    if (kind[1])      r_n = (is_nan | big) ? 64'd0 : low_ext;
    else if (is_nan)  r_n = kind[0] ? 64'd0 : min_v;
    else if (too_hi)  r_n = max_v;
    else if (too_lo)  r_n = min_v;
    else              r_n = low_ext;
  end

  wire ovf_n = is_nan | big | inexact | too_hi | too_lo;
  wire lt_n  = dst_signed & r_n[63];
  wire eq_n  = (r_n == 64'd0);
  wire gt_n  = ~lt_n & ~eq_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res  <= 64'd0;
      ovf  <= 1'b0;
      cond <= 4'b0010;
    end else if (cvt_en) begin
      res  <= r_n;
      ovf  <= ovf_n;
      cond <= {lt_n, gt_n, eq_n, cond[0] | ovf_n};
    end
  end
endmodule

// File: rtl/fp2int_cvt_chk.sv
module fp2int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cvt_en,
  input logic        dst_wide,
  input logic        dst_signed,
  input logic [63:0] res,
  input logic        ovf,
  input logic [3:0]  cond
);
  a_r8_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cond[3:1]) == 1)
    else $error("R8 condition not one-hot");

  a_r9_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cond[0] |=> cond[0])
    else $error("R9 summary bit cleared");

  a_r9_ovf_sets_so: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cond[0])
    else $error("R9 overflow without summary bit");

  a_r10_u32_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cvt_en && !dst_wide && !dst_signed) |-> (res[63:32] == 32'd0))
    else $error("R10 unsigned 32-bit upper half not zero");

  a_r10_s32_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cvt_en && !dst_wide && dst_signed) |-> (res[63:32] == {32{res[31]}}))
    else $error("R10 signed 32-bit upper half not sign extension");

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cvt_en) |-> ($stable(res) && $stable(ovf) && $stable(cond)))
    else $error("R12 outputs changed while idle");
endmodule

bind fp2int_cvt fp2int_cvt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cvt_en(cvt_en), .dst_wide(dst_wide),
  .dst_signed(dst_signed), .res(res), .ovf(ovf), .cond(cond)
);

// File: tb/fp2int_cvt_tb_top.sv
module fp2int_cvt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cvt_en = 1'b0;
  logic [63:0] src_bits = '0;
  logic src_dbl = 1'b1, dst_wide = 1'b1, dst_signed = 1'b1, force_rtz = 1'b0;
  logic [1:0] kind = 2'd0, rmode = 2'd0;
  logic [63:0] res;
  logic ovf;
  logic [3:0] cond;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp2int_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .cvt_en(cvt_en), .src_bits(src_bits),
    .src_dbl(src_dbl), .dst_wide(dst_wide), .dst_signed(dst_signed),
    .kind(kind), .rmode(rmode), .force_rtz(force_rtz),
    .res(res), .ovf(ovf), .cond(cond)
  );

  typedef struct packed {
    logic [63:0] src;
    logic        dbl, wide, sgn;
    logic [1:0]  knd, rm;
    logic        rtz;
    logic [63:0] exp_res;
    logic        exp_ovf;
    logic [2:0]  exp_cnd;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [1:0] KP = 2'd0, KS = 2'd1, KE = 2'd2, KE3 = 2'd3;
  localparam logic [1:0] RNE = 2'd0, RTZ = 2'd1, RUP = 2'd2, RDN = 2'd3;
  localparam logic [2:0] LT = 3'b100, GT = 3'b010, EQ = 3'b001;
  localparam int NV = 40;

  localparam vec_t TBL [NV] = '{
    '{64'h3FF0000000000000,1'b1,1'b1,1'b1,KP,RNE,1'b0,64'd1,1'b0,GT,8'd7},                 // R7 exact
    '{64'h4004000000000000,1'b1,1'b1,1'b1,KP,RNE,1'b0,64'd2,1'b1,GT,8'd1},                 // R1 tie even
    '{64'h400C000000000000,1'b1,1'b1,1'b1,KP,RNE,1'b0,64'd4,1'b1,GT,8'd1},                 // R1 tie up
    '{64'h4004000000000000,1'b1,1'b1,1'b1,KP,RUP,1'b0,64'd3,1'b1,GT,8'd1},                 // R1
    '{64'hC004000000000000,1'b1,1'b1,1'b1,KP,RDN,1'b0,64'hFFFFFFFFFFFFFFFD,1'b1,LT,8'd1},  // R1
    '{64'hC004000000000000,1'b1,1'b1,1'b1,KP,RTZ,1'b0,64'hFFFFFFFFFFFFFFFE,1'b1,LT,8'd1},  // R1
    '{64'h4004000000000000,1'b1,1'b1,1'b1,KP,RUP,1'b1,64'd2,1'b1,GT,8'd1},                 // R1 force
    '{64'hBFF8000000000000,1'b1,1'b0,1'b1,KS,RNE,1'b0,64'hFFFFFFFFFFFFFFFE,1'b1,LT,8'd10}, // R10
    '{64'h7FF8000000000000,1'b1,1'b0,1'b1,KP,RTZ,1'b0,64'hFFFFFFFF80000000,1'b1,LT,8'd2},  // R2
    '{64'h7FF8000000000000,1'b1,1'b1,1'b0,KP,RTZ,1'b0,64'd0,1'b1,EQ,8'd2},                 // R2
    '{64'h7FF8000000000000,1'b1,1'b1,1'b1,KS,RTZ,1'b0,64'd0,1'b1,EQ,8'd3},                 // R3
    '{64'h7FF8000000000000,1'b1,1'b0,1'b0,KS,RTZ,1'b0,64'd0,1'b1,EQ,8'd3},                 // R3
    '{64'h7FF0000000000000,1'b1,1'b0,1'b1,KP,RNE,1'b0,64'h000000007FFFFFFF,1'b1,GT,8'd4},  // R4
    '{64'h41E0000000000000,1'b1,1'b0,1'b1,KS,RTZ,1'b0,64'h000000007FFFFFFF,1'b1,GT,8'd4},  // R4
    '{64'h41F0000000000000,1'b1,1'b0,1'b0,KP,RTZ,1'b0,64'h00000000FFFFFFFF,1'b1,GT,8'd4},  // R4
    '{64'h43F0000000000000,1'b1,1'b1,1'b0,KS,RTZ,1'b0,64'hFFFFFFFFFFFFFFFF,1'b1,GT,8'd8},  // R4 R8 unsigned
    '{64'h43E0000000000000,1'b1,1'b1,1'b1,KP,RTZ,1'b0,64'h7FFFFFFFFFFFFFFF,1'b1,GT,8'd4},  // R4
    '{64'h43E0000000000000,1'b1,1'b1,1'b0,KP,RTZ,1'b0,64'h8000000000000000,1'b0,GT,8'd7},  // R7
    '{64'hFFF0000000000000,1'b1,1'b1,1'b1,KS,RTZ,1'b0,64'h8000000000000000,1'b1,LT,8'd5},  // R5
    '{64'hC1E0000000000000,1'b1,1'b0,1'b1,KP,RTZ,1'b0,64'hFFFFFFFF80000000,1'b0,LT,8'd5},  // R5 exact min
    '{64'hC1E0000000200000,1'b1,1'b0,1'b1,KP,RTZ,1'b0,64'hFFFFFFFF80000000,1'b1,LT,8'd5},  // R5
    '{64'hBFF0000000000000,1'b1,1'b0,1'b0,KP,RTZ,1'b0,64'd0,1'b1,EQ,8'd5},                 // R5
    '{64'hBFF0000000000000,1'b1,1'b0,1'b0,KE,RTZ,1'b0,64'h00000000FFFFFFFF,1'b1,GT,8'd6},  // R6
    '{64'h41F0000000500000,1'b1,1'b0,1'b1,KE,RTZ,1'b0,64'd5,1'b1,GT,8'd6},                 // R6 wrap
    '{64'h41F0000000500000,1'b1,1'b0,1'b1,KE3,RTZ,1'b0,64'd5,1'b1,GT,8'd6},                // R6 kind 11
    '{64'h41E0000000000000,1'b1,1'b0,1'b1,KE,RTZ,1'b0,64'hFFFFFFFF80000000,1'b1,LT,8'd6},  // R6
    '{64'h7FE0000000000000,1'b1,1'b1,1'b1,KE,RTZ,1'b0,64'd0,1'b1,EQ,8'd6},                 // R6 huge
    '{64'h7FF0000000000000,1'b1,1'b1,1'b1,KE,RNE,1'b0,64'd0,1'b1,EQ,8'd6},                 // R6 inf
    '{64'h7FF8000000000000,1'b1,1'b0,1'b0,KE,RNE,1'b0,64'd0,1'b1,EQ,8'd6},                 // R6 nan
    '{64'hC004000000000000,1'b1,1'b1,1'b0,KE,RNE,1'b0,64'hFFFFFFFFFFFFFFFE,1'b1,GT,8'd6},  // R6
    '{64'h0000000000000001,1'b1,1'b1,1'b1,KP,RUP,1'b0,64'd1,1'b1,GT,8'd11},                // R11
    '{64'h0000000000000001,1'b1,1'b1,1'b1,KP,RNE,1'b0,64'd0,1'b1,EQ,8'd11},                // R11
    '{64'h8000000000000001,1'b1,1'b1,1'b1,KP,RDN,1'b0,64'hFFFFFFFFFFFFFFFF,1'b1,LT,8'd11}, // R11
    '{64'h8000000000000001,1'b1,1'b0,1'b0,KS,RUP,1'b0,64'd0,1'b1,EQ,8'd11},                // R11
    '{64'hDEADBEEF3FC00000,1'b0,1'b0,1'b1,KP,RNE,1'b0,64'd2,1'b1,GT,8'd13},                // R13
    '{64'hDEADBEEF7FC00000,1'b0,1'b1,1'b1,KP,RNE,1'b0,64'h8000000000000000,1'b1,LT,8'd13}, // R13
    '{64'h00000000C0200000,1'b0,1'b0,1'b1,KS,RTZ,1'b0,64'hFFFFFFFFFFFFFFFE,1'b1,LT,8'd13}, // R13
    '{64'h123456783F800000,1'b0,1'b1,1'b0,KE,RNE,1'b0,64'd1,1'b0,GT,8'd13},                // R13
    '{64'h8000000000000000,1'b1,1'b1,1'b1,KP,RNE,1'b0,64'd0,1'b0,EQ,8'd7},                 // R7 -0.0
    '{64'h4000000000000000,1'b1,1'b0,1'b0,KP,RNE,1'b0,64'd2,1'b0,GT,8'd7}                  // R7
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic convert(input vec_t v);
    @(negedge clk);
    src_bits = v.src; src_dbl = v.dbl; dst_wide = v.wide; dst_signed = v.sgn;
    kind = v.knd; rmode = v.rm; force_rtz = v.rtz; cvt_en = 1'b1;
    @(negedge clk);
    cvt_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset res", res, 64'd0);
    check("R12 reset ovf", {63'd0, ovf}, 64'd0);
    check("R12 reset cond", {60'd0, cond}, 64'h2);

    for (int i = 0; i < NV; i++) begin
      convert(TBL[i]);
      check($sformatf("R%0d vec %0d res", TBL[i].rq, i), res, TBL[i].exp_res);
      check($sformatf("R%0d/R7 vec %0d ovf", TBL[i].rq, i), {63'd0, ovf}, {63'd0, TBL[i].exp_ovf});
      check($sformatf("R%0d/R8 vec %0d cond", TBL[i].rq, i), {61'd0, cond[3:1]}, {61'd0, TBL[i].exp_cnd});
    end

    // R9: sticky summary bit
    do_reset();
    v = TBL[0];
    convert(v);
    check("R9 exact leaves summary clear", {63'd0, cond[0]}, 64'd0);
    v = TBL[1];
    convert(v);
    check("R9 inexact sets summary", {63'd0, cond[0]}, 64'd1);
    v = TBL[0];
    convert(v);
    check("R9 summary stays after exact", {63'd0, cond[0]}, 64'd1);
    check("R9 ovf of exact is 0", {63'd0, ovf}, 64'd0);
    do_reset();
    @(negedge clk);
    check("R9 reset clears summary", {63'd0, cond[0]}, 64'd0);

    // R12: outputs hold while idle
    v = TBL[3];
    convert(v);
    @(negedge clk);
    src_bits = 64'h7FF8000000000000; kind = KP; dst_wide = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 hold res", res, 64'd3);
    check("R12 hold cond", {60'd0, cond}, 64'h5);

    // R13: upper half ignored for binary32
    v = TBL[34];
    v.src[63:32] = 32'h0;
    convert(v);
    check("R13 upper half ignored", res, 64'd2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule